// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between the clock-generation core of a multi-output clock generator and its output drivers. Four clock domains feed it: the CPU-rate clock, which also drives the CPU, chipset and interrupt-controller outputs; the PCI-rate clock, which also drives the 66 MHz outputs; the fixed 48 MHz clock, which drives the 48 MHz and 24/48 MHz outputs; and the crystal reference clock. For every output it produces a gate enable and a gated clock. An output runs only when its configuration bit is 1 and the sequencer is not stopping the clocks.

An asynchronous active-low power-down pin is synchronized into the CPU domain. A controller there raises a stop request, and each domain carries that request through its own synchronizer. Each domain parks its outputs low on a falling edge of its own clock and then reports back that it has parked. Only when every domain has parked does the controller drop the VCO enable, and only after that the crystal-oscillator enable. A status output then marks the part as fully down. When the pin is released, both enables come back together. A settle counter stands in for the lock time, and when it expires the gates re-open, each on a falling edge. A separate tristate bit is passed out as an active-high output-disable for the drivers.

Top module: `clkout_pd_seq`

## Requirements
- R1: While reset is applied, every gate enable is 0, osc_en and vco_en are 1 and pd_done is 0.
- R2: pd_n is sampled only by a two-flop synchronizer on cpu_clk. A low pulse that spans no cpu_clk rising edge has no effect. A sustained low on pd_n drives every gate enable to 0 within 5 cpu_clk periods plus (stages + 3) periods of the slowest domain clock.
- R3: A gate enable changes only while its source clock is low. Every high pulse on a gated clock therefore lasts exactly half a source period.
- R4: While pd_done is 1, every gate enable stays 0 whatever the configuration bits are.
- R5: Outside power-down and settle, each gate enable follows its configuration bit: bit value 1 runs that output, and bit value 0 holds it low with no toggles.
- R6: vco_en falls only after every gate enable in all four domains is 0. osc_en falls only after vco_en is already 0.
- R7: pd_done is 1 only while both osc_en and vco_en are 0.
- R8: After reset or after pd_n is released, osc_en and vco_en are 1 and the gates stay closed for SETTLE_CYC cpu_clk cycles before they re-open.
- R9: oe_n equals cfg_tristate: a value of 1 requests high impedance on all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-rate clock. Clocks the controller and the CPU-domain gates |
| pci_clk | input | 1 | PCI-rate free-running clock |
| fix_clk | input | 1 | Fixed 48 MHz clock |
| ref_clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cfg_tristate | input | 1 | 1 requests that all outputs go to high impedance |
| cfg_cpu_en | input | N_CPU | Per-output enables for the CPU, chipset and interrupt-controller outputs |
| cfg_pci_en | input | N_PCI | Per-output enables for the PCI and 66 MHz outputs |
| cfg_fix_en | input | N_FIX | Per-output enables for the 48 and 24/48 MHz outputs |
| cfg_ref_en | input | N_REF | Per-output enables for the reference outputs |
| cpu_gate_en | output | N_CPU | Gate enables, CPU domain |
| cpu_gclk | output | N_CPU | Gated clocks, CPU domain |
| pci_gate_en | output | N_PCI | Gate enables, PCI domain |
| pci_gclk | output | N_PCI | Gated clocks, PCI domain |
| fix_gate_en | output | N_FIX | Gate enables, 48 MHz domain |
| fix_gclk | output | N_FIX | Gated clocks, 48 MHz domain |
| ref_gate_en | output | N_REF | Gate enables, reference domain |
| ref_gclk | output | N_REF | Gated clocks, reference domain |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL VCO enable |
| oe_n | output | 1 | Output-disable for the drivers, 1 means high impedance |
| pd_done | output | 1 | Power-down complete |

## Verification
The assertions check on every cycle that the gate enables never move during the high phase of their clocks, and that the shutdown order holds: parked gates before the VCO goes off, the VCO before the oscillator, and both off before pd_done. They also check that the gates stay shut while the block is fully down. The latency bound, the settle wait after release, the configuration sweeps, and the rejection of a short pd_n pulse depend on the input stimulus and the relative clock phases, so only the bench scenarios can show them. The bench also measures each gated clock's pulse widths against half the source period.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [2:0] {
    PS_WAKE    = 3'd0,
    PS_RUN     = 3'd1,
    PS_PARK    = 3'd2,
    PS_VCO_OFF = 3'd3,
    PS_OSC_OFF = 3'd4,
    PS_DOWN    = 3'd5
  } pdseq_state_e;

  // Gates are closed in every state except RUN.
  function automatic logic stop_of(pdseq_state_e s);
    return s != PS_RUN;
  endfunction

  function automatic logic vco_of(pdseq_state_e s);
    return !(s inside {PS_VCO_OFF, PS_OSC_OFF, PS_DOWN});
  endfunction

  function automatic logic osc_of(pdseq_state_e s);
    return !(s inside {PS_OSC_OFF, PS_DOWN});
  endfunction

  function automatic logic done_of(pdseq_state_e s);
    return s == PS_DOWN;
  endfunction

  // The wake window lasts lim cycles: counts 0 .. lim-1.
  function automatic logic settle_done(int unsigned cnt, int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] one_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) one_q <= {W{RST_VAL}};
        else        one_q <= d;
      end
      assign q = one_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{ {W{RST_VAL}} }};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pdseq_gate_bank.sv
module pdseq_gate_bank #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_req,
  input  logic [W-1:0] cfg_en,
  output logic [W-1:0] gate_en,
  output logic [W-1:0] gclk,
  output logic         parked
);

  logic         stop_s;
  logic [W-1:0] cfg_s;
  logic [W-1:0] gate_next;

  pdseq_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) i_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(stop_req), .q(stop_s)
  );

  pdseq_sync #(.W(W), .STAGES(2), .RST_VAL(1'b0)) i_cfg_sync (
    .clk(clk), .rst_n(rst_n), .d(cfg_en), .q(cfg_s)
  );

  assign gate_next = stop_s ? '0 : cfg_s;

  // Enables update on the falling edge only, so a gated pulse is never cut short.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en <= '0;
      parked  <= 1'b1;
    end else begin
      gate_en <= gate_next;
      parked  <= stop_s;
    end
  end

  assign gclk = {W{clk}} & gate_en;

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter int SETTLE_CYC = 64,
  parameter int N_DOM      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic [N_DOM-1:0] park_ack,
  output logic             stop_req,
  output logic             vco_en,
  output logic             osc_en,
  output logic             pd_done,
  output logic             all_parked,
  output logic             none_parked
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  pdseq_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [N_DOM-1:0] ack_s;

  pdseq_sync #(.W(N_DOM), .STAGES(2), .RST_VAL(1'b1)) i_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(park_ack), .q(ack_s)
  );

  assign all_parked  = &ack_s;
  assign none_parked = ~|ack_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_WAKE:    if (settle_done(32'(cnt_q), SETTLE_CYC)) state_d = PS_RUN;
      PS_RUN:     if (pd_req && none_parked) state_d = PS_PARK;
      PS_PARK:    if (all_parked) state_d = PS_VCO_OFF;
      PS_VCO_OFF: state_d = PS_OSC_OFF;
      PS_OSC_OFF: state_d = PS_DOWN;
      PS_DOWN:    if (!pd_req) state_d = PS_WAKE;
      default:    state_d = PS_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_WAKE;
      cnt_q    <= '0;
      stop_req <= 1'b1;
      vco_en   <= 1'b1;
      osc_en   <= 1'b1;
      pd_done  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= (state_q == PS_WAKE && state_d == PS_WAKE) ? cnt_q + CNT_W'(1) : '0;
      stop_req <= stop_of(state_d);
      vco_en   <= vco_of(state_d);
      osc_en   <= osc_of(state_d);
      pd_done  <= done_of(state_d);
    end
  end

endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq #(
  parameter int N_CPU       = 7,
  parameter int N_PCI       = 14,
  parameter int N_FIX       = 2,
  parameter int N_REF       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REF_STAGES  = 3,
  parameter int SETTLE_CYC  = 64
) (
  input  logic             cpu_clk,
  input  logic             pci_clk,
  input  logic             fix_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             cfg_tristate,
  input  logic [N_CPU-1:0] cfg_cpu_en,
  input  logic [N_PCI-1:0] cfg_pci_en,
  input  logic [N_FIX-1:0] cfg_fix_en,
  input  logic [N_REF-1:0] cfg_ref_en,
  output logic [N_CPU-1:0] cpu_gate_en,
  output logic [N_CPU-1:0] cpu_gclk,
  output logic [N_PCI-1:0] pci_gate_en,
  output logic [N_PCI-1:0] pci_gclk,
  output logic [N_FIX-1:0] fix_gate_en,
  output logic [N_FIX-1:0] fix_gclk,
  output logic [N_REF-1:0] ref_gate_en,
  output logic [N_REF-1:0] ref_gclk,
  output logic             osc_en,
  output logic             vco_en,
  output logic             oe_n,
  output logic             pd_done
);

  localparam int N_DOM = 4;

  logic             pd_n_s;
  logic             pd_req;
  logic             stop_req;
  logic             all_parked;
  logic             none_parked;
  logic [N_DOM-1:0] park_ack;

  pdseq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) i_pd_sync (
    .clk(cpu_clk), .rst_n(rst_n), .d(pd_n), .q(pd_n_s)
  );

  assign pd_req = ~pd_n_s;

  pdseq_fsm #(.SETTLE_CYC(SETTLE_CYC), .N_DOM(N_DOM)) i_fsm (
    .clk(cpu_clk), .rst_n(rst_n), .pd_req(pd_req), .park_ack(park_ack),
    .stop_req(stop_req), .vco_en(vco_en), .osc_en(osc_en), .pd_done(pd_done),
    .all_parked(all_parked), .none_parked(none_parked)
  );

  pdseq_gate_bank #(.W(N_CPU), .STAGES(SYNC_STAGES)) i_cpu_bank (
    .clk(cpu_clk), .rst_n(rst_n), .stop_req(stop_req), .cfg_en(cfg_cpu_en),
    .gate_en(cpu_gate_en), .gclk(cpu_gclk), .parked(park_ack[0])
  );

  pdseq_gate_bank #(.W(N_PCI), .STAGES(SYNC_STAGES)) i_pci_bank (
    .clk(pci_clk), .rst_n(rst_n), .stop_req(stop_req), .cfg_en(cfg_pci_en),
    .gate_en(pci_gate_en), .gclk(pci_gclk), .parked(park_ack[1])
  );

  pdseq_gate_bank #(.W(N_FIX), .STAGES(SYNC_STAGES)) i_fix_bank (
    .clk(fix_clk), .rst_n(rst_n), .stop_req(stop_req), .cfg_en(cfg_fix_en),
    .gate_en(fix_gate_en), .gclk(fix_gclk), .parked(park_ack[2])
  );

  // The reference domain gets a deeper chain: it may need extra cycles to settle low.
  pdseq_gate_bank #(.W(N_REF), .STAGES(REF_STAGES)) i_ref_bank (
    .clk(ref_clk), .rst_n(rst_n), .stop_req(stop_req), .cfg_en(cfg_ref_en),
    .gate_en(ref_gate_en), .gclk(ref_gclk), .parked(park_ack[3])
  );

  assign oe_n = cfg_tristate;

endmodule

// File: rtl/clkout_pd_seq_chk.sv
module clkout_pd_seq_chk #(
  parameter int N_CPU = 7,
  parameter int N_PCI = 14,
  parameter int N_FIX = 2,
  parameter int N_REF = 2
) (
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             fix_clk,
  input logic             ref_clk,
  input logic             rst_n,
  input logic [N_CPU-1:0] cpu_gate_en,
  input logic [N_PCI-1:0] pci_gate_en,
  input logic [N_FIX-1:0] fix_gate_en,
  input logic [N_REF-1:0] ref_gate_en,
  input logic             vco_en,
  input logic             osc_en,
  input logic             pd_done
);

  logic [N_CPU-1:0] cpu_en_hi;
  logic [N_PCI-1:0] pci_en_hi;
  logic [N_FIX-1:0] fix_en_hi;
  logic [N_REF-1:0] ref_en_hi;
  logic             gates_closed;

  assign gates_closed = (cpu_gate_en == '0) && (pci_gate_en == '0) &&
                        (fix_gate_en == '0) && (ref_gate_en == '0);

  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) cpu_en_hi <= '0; else cpu_en_hi <= cpu_gate_en;
  always_ff @(posedge pci_clk or negedge rst_n)
    if (!rst_n) pci_en_hi <= '0; else pci_en_hi <= pci_gate_en;
  always_ff @(posedge fix_clk or negedge rst_n)
    if (!rst_n) fix_en_hi <= '0; else fix_en_hi <= fix_gate_en;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_en_hi <= '0; else ref_en_hi <= ref_gate_en;

  AST_CPU_GATE_STEADY_HIGH: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    cpu_gate_en == cpu_en_hi);  // R3
  AST_PCI_GATE_STEADY_HIGH: assert property (@(negedge pci_clk) disable iff (!rst_n)
    pci_gate_en == pci_en_hi);  // R3
  AST_FIX_GATE_STEADY_HIGH: assert property (@(negedge fix_clk) disable iff (!rst_n)
    fix_gate_en == fix_en_hi);  // R3
  AST_REF_GATE_STEADY_HIGH: assert property (@(negedge ref_clk) disable iff (!rst_n)
    ref_gate_en == ref_en_hi);  // R3

  AST_DOWN_GATES_SHUT: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    pd_done |-> gates_closed);  // R4
  AST_VCO_OFF_AFTER_PARK: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(vco_en) |-> gates_closed);  // R6
  AST_OSC_OFF_AFTER_VCO: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(osc_en) |-> !vco_en);  // R6
  AST_DONE_ONLY_WHEN_OFF: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    pd_done |-> (!osc_en && !vco_en));  // R7

endmodule

bind clkout_pd_seq clkout_pd_seq_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_FIX(N_FIX), .N_REF(N_REF)
) i_chk (
  .cpu_clk(cpu_clk), .pci_clk(pci_clk), .fix_clk(fix_clk), .ref_clk(ref_clk),
  .rst_n(rst_n), .cpu_gate_en(cpu_gate_en), .pci_gate_en(pci_gate_en),
  .fix_gate_en(fix_gate_en), .ref_gate_en(ref_gate_en),
  .vco_en(vco_en), .osc_en(osc_en), .pd_done(pd_done)
);

// File: tb/test_clkout_pd_seq.sv
`timescale 1ns/1ps

module test_pulse_mon #(parameter real HALF = 10.0) (
  input  logic sig,
  output logic bad
);
  realtime t_rise = 0.0;
  initial bad = 1'b0;
  always @(posedge sig) t_rise = $realtime;
  always @(negedge sig) begin
    if (($realtime - t_rise) > HALF + 0.01 || ($realtime - t_rise) < HALF - 0.01) begin
      bad = 1'b1;
      $display("pulse width error: %0t high for %0t", $realtime, $realtime - t_rise);
    end
  end
endmodule

module test_clkout_pd_seq;
  localparam int  N_CPU = 7, N_PCI = 14, N_FIX = 2, N_REF = 2;
  localparam int  SETTLE = 64;
  localparam real H_CPU = 10.0, H_PCI = 20.0, H_FIX = 13.5, H_REF = 35.0;
  localparam real STOP_BOUND = 5 * 2 * H_CPU + (3 + 3) * 2 * H_REF;

  logic cpu_clk = 0, pci_clk = 0, fix_clk = 0, ref_clk = 0;
  logic rst_n = 0, pd_n = 1, cfg_tristate = 0;
  logic [N_CPU-1:0] cfg_cpu_en = '1;
  logic [N_PCI-1:0] cfg_pci_en = '1;
  logic [N_FIX-1:0] cfg_fix_en = '1;
  logic [N_REF-1:0] cfg_ref_en = '1;
  logic [N_CPU-1:0] cpu_gate_en, cpu_gclk;
  logic [N_PCI-1:0] pci_gate_en, pci_gclk;
  logic [N_FIX-1:0] fix_gate_en, fix_gclk;
  logic [N_REF-1:0] ref_gate_en, ref_gclk;
  logic osc_en, vco_en, oe_n, pd_done;

  int total = 0, bad = 0, pci0_edges = 0;
  bit finished = 0;

  always #(H_CPU) cpu_clk = ~cpu_clk;
  always #(H_PCI) pci_clk = ~pci_clk;
  always #(H_FIX) fix_clk = ~fix_clk;
  always #(H_REF) ref_clk = ~ref_clk;
  always @(posedge pci_gclk[0]) pci0_edges++;

  clkout_pd_seq #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_FIX(N_FIX), .N_REF(N_REF),
                  .SETTLE_CYC(SETTLE)) i_clkout_pd_seq (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .fix_clk(fix_clk), .ref_clk(ref_clk),
    .rst_n(rst_n), .pd_n(pd_n), .cfg_tristate(cfg_tristate),
    .cfg_cpu_en(cfg_cpu_en), .cfg_pci_en(cfg_pci_en), .cfg_fix_en(cfg_fix_en),
    .cfg_ref_en(cfg_ref_en), .cpu_gate_en(cpu_gate_en), .cpu_gclk(cpu_gclk),
    .pci_gate_en(pci_gate_en), .pci_gclk(pci_gclk), .fix_gate_en(fix_gate_en),
    .fix_gclk(fix_gclk), .ref_gate_en(ref_gate_en), .ref_gclk(ref_gclk),
    .osc_en(osc_en), .vco_en(vco_en), .oe_n(oe_n), .pd_done(pd_done)
  );

  logic [N_CPU-1:0] mb_cpu;
  logic [N_PCI-1:0] mb_pci;
  logic [N_FIX-1:0] mb_fix;
  logic [N_REF-1:0] mb_ref;
  for (genvar i = 0; i < N_CPU; i++) begin : g_mc
    test_pulse_mon #(.HALF(H_CPU)) i_m (.sig(cpu_gclk[i]), .bad(mb_cpu[i]));
  end
  for (genvar i = 0; i < N_PCI; i++) begin : g_mp
    test_pulse_mon #(.HALF(H_PCI)) i_m (.sig(pci_gclk[i]), .bad(mb_pci[i]));
  end
  for (genvar i = 0; i < N_FIX; i++) begin : g_mf
    test_pulse_mon #(.HALF(H_FIX)) i_m (.sig(fix_gclk[i]), .bad(mb_fix[i]));
  end
  for (genvar i = 0; i < N_REF; i++) begin : g_mr
    test_pulse_mon #(.HALF(H_REF)) i_m (.sig(ref_gclk[i]), .bad(mb_ref[i]));
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Move to a sample point that no clock edge shares.
  task automatic align();
    @(posedge cpu_clk);
    #5.25;
  endtask

  function automatic logic [31:0] pat(int p, int w);
    logic [31:0] v = '0;
    for (int b = 0; b < w; b++) v[b] = (p == 0) ? 1'b1 : (((b + p) % (p + 1)) != 0);
    return v;
  endfunction

  task automatic set_cfg(input int p);
    cfg_cpu_en = pat(p, N_CPU)[N_CPU-1:0];
    cfg_pci_en = pat(p, N_PCI)[N_PCI-1:0];
    cfg_fix_en = pat(p, N_FIX)[N_FIX-1:0];
    cfg_ref_en = pat(p, N_REF)[N_REF-1:0];
  endtask

  task automatic chk_gates(input string req, input bit shut);
    chk({req, " cpu gates"}, 32'(cpu_gate_en), shut ? 32'd0 : 32'(cfg_cpu_en));
    chk({req, " pci gates"}, 32'(pci_gate_en), shut ? 32'd0 : 32'(cfg_pci_en));
    chk({req, " fix gates"}, 32'(fix_gate_en), shut ? 32'd0 : 32'(cfg_fix_en));
    chk({req, " ref gates"}, 32'(ref_gate_en), shut ? 32'd0 : 32'(cfg_ref_en));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(posedge cpu_clk);
    #5.25;
    // R1: reset state
    chk_gates("R1", 1'b1);
    chk("R1 osc_en", 32'(osc_en), 32'd1);
    chk("R1 vco_en", 32'(vco_en), 32'd1);
    chk("R1 pd_done", 32'(pd_done), 32'd0);
    rst_n = 1;
    repeat (SETTLE - 6) @(posedge cpu_clk);
    #5.25;
    chk_gates("R8 settle after reset", 1'b1);
    #2000;
    align();
    chk_gates("R5 all on", 1'b0);

    // R5: configuration sweep
    for (int p = 1; p < 6; p++) begin
      set_cfg(p);
      #600;
      align();
      chk_gates($sformatf("R5 pattern %0d", p), 1'b0);
    end
    set_cfg(0);
    #600;
    align();

    // R5: disabled output does not toggle, enabled one does
    begin
      int c0;
      cfg_pci_en[0] = 1'b0;
      #400; align();
      c0 = pci0_edges;
      #1000; align();
      chk("R5 pci0 disabled edges", 32'(pci0_edges - c0), 32'd0);
      cfg_pci_en[0] = 1'b1;
      #400; align();
      c0 = pci0_edges;
      #1000; align();
      chk("R5 pci0 enabled runs", 32'((pci0_edges - c0) >= 20), 32'd1);
    end

    // R9: tristate
    cfg_tristate = 1; #1; chk("R9 oe_n high", 32'(oe_n), 32'd1);
    cfg_tristate = 0; #1; chk("R9 oe_n low", 32'(oe_n), 32'd0);

    // R2: short low pulse between cpu edges is not seen
    @(posedge cpu_clk); #2; pd_n = 0; #5; pd_n = 1;
    #1000; align();
    chk("R2 short pulse vco_en", 32'(vco_en), 32'd1);
    chk_gates("R2 short pulse", 1'b0);

    // Power-down cycles at different phases
    for (int k = 0; k < 3; k++) begin
      align();
      #(k * 3.1 + 1.3);
      pd_n = 0;
      #(STOP_BOUND);
      align();
      chk_gates($sformatf("R2 stop latency %0d", k), 1'b1);
      #1500; align();
      chk("R6 vco off", 32'(vco_en), 32'd0);
      chk("R6 osc off", 32'(osc_en), 32'd0);
      chk("R7 pd_done", 32'(pd_done), 32'd1);
      set_cfg(k + 1);
      #600; align();
      chk_gates("R4 cfg ignored while down", 1'b1);
      pd_n = 1;
      repeat (5) @(posedge cpu_clk);
      #5.25;
      chk("R8 osc back", 32'(osc_en), 32'd1);
      chk("R8 vco back", 32'(vco_en), 32'd1);
      chk("R8 pd_done clear", 32'(pd_done), 32'd0);
      chk_gates("R8 gates closed in settle", 1'b1);
      #(SETTLE * 2 * H_CPU + 700);
      align();
      chk_gates($sformatf("R8 gates reopen %0d", k), 1'b0);
      set_cfg(0);
      #600; align();
    end

    // R3: pulse widths measured throughout
    chk("R3 cpu pulse widths", 32'(mb_cpu), 32'd0);
    chk("R3 pci pulse widths", 32'(mb_pci), 32'd0);
    chk("R3 fix pulse widths", 32'(mb_fix), 32'd0);
    chk("R3 ref pulse widths", 32'(mb_ref), 32'd0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #2ms;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule